// File: doc/BRIEF.md
# Warp Divergence Mask Tracker

This block follows the lane-enable mask of a single 32-lane warp as it runs through two-way conditional branches. All lanes of a warp share one instruction stream. When a branch arrives, the block compares the per-lane condition bits with the lanes that are live at that moment.

If the live lanes all agree, the warp simply moves to the agreed path and the mask stays as it is. If they disagree, the block opens a reconvergence record. It first runs the taken path for the lanes whose condition is true. When the fetch stream reaches the reconvergence address, it switches to the fall-through path for the other live lanes. On the second arrival at that address, it restores the mask that was in force at the branch.

Records nest on a small last-in-first-out stack. A branch that would need a record while the stack is full is refused, and a sticky flag is raised. Besides the mask, the block reports three things: which path source the fetch side should follow, with an optional redirect address; the depth of the stack; and a count of the issue cycles spent inside divergent regions. The count is the serialisation cost, which is the sum of the lengths of both sides.

Top module: `ds_diverge_unit`

## Requirements
- R1: After reset the active mask is all ones, the stack depth is 0, the overflow flag is 0, the serialisation count is 0, the path select is 0 (sequential) and no redirect is issued.
- R2: When the live lanes agree on a branch, the mask is unchanged and no record is pushed. If all live lanes are true, or no lane is live, the block redirects to the taken address; if all live lanes are false, it redirects to the fall-through address. The path select is 1 (taken) or 2 (fall-through) for one cycle.
- R3: A split branch pushes one record, sets the mask to the live lanes whose condition is 1, and redirects to the taken address with path select 1.
- R4: A lane that is inactive when a branch arrives stays inactive on both paths of that branch, whatever its condition bit.
- R5: The first time an issued address equals the reconvergence address of the top record, the mask becomes the live-at-entry lanes whose condition was 0, and the block redirects to the fall-through address with path select 2.
- R6: The second time an issued address equals the reconvergence address, the record is popped and the entry mask returns, with path select 3 (reconverged) and no redirect.
- R7: Records nest last-in-first-out up to a depth of 8. Each level reconverges to its own entry mask.
- R8: A split branch arriving while 8 records are held sets a sticky overflow flag. That branch has no other effect: the mask and depth are unchanged, there is no redirect, and the path select is 0.
- R9: The serialisation count increases by one on every issue cycle that starts with at least one record on the stack, and holds otherwise.
- R10: When a branch and a reconvergence hit fall in the same cycle, two cases apply. If the hit pops a record, the branch is judged against the restored mask, and it may push into the freed slot. If the hit switches to the fall-through side, the branch is dropped.
- R11: A cycle with no branch and no reconvergence hit gives path select 0 and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_en | input | 1 | A branch is resolved this cycle |
| br_cond | input | 32 | Per-lane branch condition |
| br_taken_pc | input | 32 | Address of the taken path |
| br_else_pc | input | 32 | Address of the fall-through path |
| br_reconv_pc | input | 32 | Address where both paths meet |
| pc_en | input | 1 | An instruction issues this cycle |
| pc_now | input | 32 | Address of the issuing instruction |
| active_mask | output | 32 | Lanes enabled for execution |
| path_sel | output | 2 | 0 sequential, 1 taken, 2 fall-through, 3 reconverged |
| redirect_valid | output | 1 | Fetch must jump to redirect_pc |
| redirect_pc | output | 32 | Redirect address |
| stack_depth | output | 4 | Records currently held |
| overflow | output | 1 | Sticky: a split was refused on a full stack |
| serial_cycles | output | 16 | Issue cycles spent inside divergent regions |

## Verification
Two functions can fall in the same cycle: the branch evaluation and the reconvergence hit. The bench provokes this by resolving a branch in the very cycle that the issued address equals the top record's reconvergence address, once on the pop arrival and once on the switch arrival. In the pop case, the expected mask is the restored entry mask narrowed by the new condition, with the depth unchanged. In the switch case, the expected result is the fall-through redirect with no trace of the branch.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int unsigned WARP_LANES  = 32;
  localparam int unsigned ADDR_BITS   = 32;
  localparam int unsigned STACK_SLOTS = 8;
  localparam int unsigned COUNT_BITS  = 16;

  typedef enum logic [1:0] {
    PATH_SEQ    = 2'd0,
    PATH_TAKEN  = 2'd1,
    PATH_ELSE   = 2'd2,
    PATH_RECONV = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    BR_ALL_TRUE  = 2'd0,
    BR_ALL_FALSE = 2'd1,
    BR_SPLIT     = 2'd2
  } br_kind_e;
endpackage

// File: rtl/ds_branch_eval.sv
module ds_branch_eval #(
  parameter int unsigned LANES = 32
) (
  input  logic [LANES-1:0] live_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken_mask,
  output logic [LANES-1:0] else_mask,
  output ds_pkg::br_kind_e kind
);
  function automatic logic [LANES-1:0] lanes_true(input logic [LANES-1:0] m,
                                                  input logic [LANES-1:0] c);
    return m & c;
  endfunction

  function automatic logic [LANES-1:0] lanes_false(input logic [LANES-1:0] m,
                                                   input logic [LANES-1:0] c);
    return m & ~c;
  endfunction

  always_comb begin
    taken_mask = lanes_true(live_mask, cond);
    else_mask  = lanes_false(live_mask, cond);
    if (taken_mask != '0 && else_mask != '0) kind = ds_pkg::BR_SPLIT;
    else if (else_mask != '0)                kind = ds_pkg::BR_ALL_FALSE;
    else                                     kind = ds_pkg::BR_ALL_TRUE;
  end
endmodule

// File: rtl/ds_recon_stack.sv
module ds_recon_stack #(
  parameter int unsigned LANES = 32,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flip,
  input  logic [PC_W-1:0]  push_reconv,
  input  logic [PC_W-1:0]  push_else_pc,
  input  logic [LANES-1:0] push_else_mask,
  input  logic [LANES-1:0] push_entry_mask,
  output logic [PC_W-1:0]  top_reconv,
  output logic [PC_W-1:0]  top_else_pc,
  output logic [LANES-1:0] top_else_mask,
  output logic [LANES-1:0] top_entry_mask,
  output logic             top_phase,
  output logic [DW-1:0]    depth,
  output logic             empty,
  output logic             full
);
  logic [PC_W-1:0]  reconv_a [DEPTH];
  logic [PC_W-1:0]  elsepc_a [DEPTH];
  logic [LANES-1:0] elsem_a  [DEPTH];
  logic [LANES-1:0] entrym_a [DEPTH];
  logic [DEPTH-1:0] phase_a;
  logic [DW-1:0]    depth_q;
  logic [IW-1:0]    top_idx;
  logic [IW-1:0]    wr_idx;
  logic [DW-1:0]    wr_slot;

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == DW'(DEPTH));
  assign depth   = depth_q;
  assign top_idx = empty ? '0 : IW'(depth_q - DW'(1));
  assign wr_slot = depth_q - DW'(pop);
  assign wr_idx  = IW'(wr_slot);

  assign top_reconv     = reconv_a[top_idx];
  assign top_else_pc    = elsepc_a[top_idx];
  assign top_else_mask  = elsem_a[top_idx];
  assign top_entry_mask = entrym_a[top_idx];
  assign top_phase      = phase_a[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      phase_a <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        reconv_a[i] <= '0;
        elsepc_a[i] <= '0;
        elsem_a[i]  <= '0;
        entrym_a[i] <= '0;
      end
    end else begin
      depth_q <= depth_q + DW'(push) - DW'(pop);
      if (push) begin
        reconv_a[wr_idx] <= push_reconv;
        elsepc_a[wr_idx] <= push_else_pc;
        elsem_a[wr_idx]  <= push_else_mask;
        entrym_a[wr_idx] <= push_entry_mask;
        phase_a[wr_idx]  <= 1'b0;
      end else if (flip) begin
        phase_a[top_idx] <= 1'b1;
      end
    end
  end

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH));
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || flip) |-> !empty);
endmodule

// File: rtl/ds_serial_cnt.sv
module ds_serial_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= bump(count);
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/ds_diverge_unit.sv
module ds_diverge_unit #(
  parameter int unsigned LANES = ds_pkg::WARP_LANES,
  parameter int unsigned PC_W  = ds_pkg::ADDR_BITS,
  parameter int unsigned DEPTH = ds_pkg::STACK_SLOTS,
  parameter int unsigned CNT_W = ds_pkg::COUNT_BITS,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_en,
  input  logic [LANES-1:0] br_cond,
  input  logic [PC_W-1:0]  br_taken_pc,
  input  logic [PC_W-1:0]  br_else_pc,
  input  logic [PC_W-1:0]  br_reconv_pc,
  input  logic             pc_en,
  input  logic [PC_W-1:0]  pc_now,
  output logic [LANES-1:0] active_mask,
  output logic [1:0]       path_sel,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [DW-1:0]    stack_depth,
  output logic             overflow,
  output logic [CNT_W-1:0] serial_cycles
);
  import ds_pkg::*;

  logic [PC_W-1:0]  top_reconv, top_else_pc;
  logic [LANES-1:0] top_else_mask, top_entry_mask;
  logic             top_phase, stk_empty, stk_full;
  logic [DW-1:0]    depth_w;

  logic             reconv_hit, flip_now, pop_now, br_live, room_mid;
  logic             split_now, push_now, refuse_now, uniform_now;
  logic [LANES-1:0] mask_mid, eval_taken, eval_else;
  br_kind_e         eval_kind;

  logic [LANES-1:0] mask_d;
  path_e            path_d;
  logic             redir_d;
  logic [PC_W-1:0]  redir_pc_d;

  // reconvergence detection against the top record
  assign reconv_hit = pc_en && !stk_empty && (pc_now == top_reconv);
  assign flip_now   = reconv_hit && !top_phase;
  assign pop_now    = reconv_hit && top_phase;
  // mask the branch is judged against: restored when the record pops
  assign mask_mid   = pop_now ? top_entry_mask : active_mask;
  assign br_live    = br_en && !flip_now;
  assign room_mid   = !stk_full || pop_now;

  ds_branch_eval #(.LANES(LANES)) u_eval (
    .live_mask  (mask_mid),
    .cond       (br_cond),
    .taken_mask (eval_taken),
    .else_mask  (eval_else),
    .kind       (eval_kind)
  );

  assign split_now   = br_live && (eval_kind == BR_SPLIT);
  assign push_now    = split_now && room_mid;
  assign refuse_now  = split_now && !room_mid;
  assign uniform_now = br_live && (eval_kind != BR_SPLIT);

  ds_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk             (clk),
    .rst_n           (rst_n),
    .push            (push_now),
    .pop             (pop_now),
    .flip            (flip_now),
    .push_reconv     (br_reconv_pc),
    .push_else_pc    (br_else_pc),
    .push_else_mask  (eval_else),
    .push_entry_mask (mask_mid),
    .top_reconv      (top_reconv),
    .top_else_pc     (top_else_pc),
    .top_else_mask   (top_else_mask),
    .top_entry_mask  (top_entry_mask),
    .top_phase       (top_phase),
    .depth           (depth_w),
    .empty           (stk_empty),
    .full            (stk_full)
  );

  ds_serial_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pc_en && !stk_empty),
    .count (serial_cycles)
  );

  always_comb begin
    mask_d     = mask_mid;
    path_d     = PATH_SEQ;
    redir_d    = 1'b0;
    redir_pc_d = '0;
    if (push_now) begin
      mask_d     = eval_taken;
      path_d     = PATH_TAKEN;
      redir_d    = 1'b1;
      redir_pc_d = br_taken_pc;
    end else if (uniform_now && eval_kind == BR_ALL_FALSE) begin
      path_d     = PATH_ELSE;
      redir_d    = 1'b1;
      redir_pc_d = br_else_pc;
    end else if (uniform_now) begin
      path_d     = PATH_TAKEN;
      redir_d    = 1'b1;
      redir_pc_d = br_taken_pc;
    end else if (flip_now) begin
      mask_d     = top_else_mask;
      path_d     = PATH_ELSE;
      redir_d    = 1'b1;
      redir_pc_d = top_else_pc;
    end else if (pop_now) begin
      path_d     = PATH_RECONV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask    <= '1;
      path_sel       <= PATH_SEQ;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      overflow       <= 1'b0;
    end else begin
      active_mask    <= mask_d;
      path_sel       <= path_d;
      redirect_valid <= redir_d;
      redirect_pc    <= redir_pc_d;
      if (refuse_now) overflow <= 1'b1;
    end
  end

  assign stack_depth = depth_w;

  assert_uniform_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uniform_now && !pop_now) |=> $stable(active_mask));
  assert_split_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_now && !pop_now) |=> stack_depth == $past(stack_depth) + DW'(1));
  assert_inactive_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_now && !pop_now) |=> (active_mask & ~$past(active_mask)) == '0);
  assert_else_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flip_now |=> (active_mask & $past(active_mask)) == '0);
  assert_pop_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_now && !br_en) |=> active_mask == $past(top_entry_mask));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_now |=> overflow && $stable(active_mask) && $stable(stack_depth));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_flip_drops_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flip_now |=> path_sel == PATH_ELSE && $stable(stack_depth));
endmodule

// File: tb/test_ds_diverge_unit.sv
module test_ds_diverge_unit;
  localparam int L = 32;
  localparam int P = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         br_en = 1'b0;
  logic [L-1:0] br_cond = '0;
  logic [P-1:0] br_taken_pc = '0, br_else_pc = '0, br_reconv_pc = '0;
  logic         pc_en = 1'b0;
  logic [P-1:0] pc_now = '0;
  logic [L-1:0] active_mask;
  logic [1:0]   path_sel;
  logic         redirect_valid;
  logic [P-1:0] redirect_pc;
  logic [3:0]   stack_depth;
  logic         overflow;
  logic [15:0]  serial_cycles;

  always #10 clk = ~clk;

  ds_diverge_unit i_ds_diverge_unit (
    .clk(clk), .rst_n(rst_n), .br_en(br_en), .br_cond(br_cond),
    .br_taken_pc(br_taken_pc), .br_else_pc(br_else_pc), .br_reconv_pc(br_reconv_pc),
    .pc_en(pc_en), .pc_now(pc_now), .active_mask(active_mask), .path_sel(path_sel),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stack_depth(stack_depth), .overflow(overflow), .serial_cycles(serial_cycles)
  );

  int n_chk = 0, n_bad = 0;

  // reference state, kept from the requirements
  logic [L-1:0] m_mask;
  int           m_depth, m_cnt;
  logic         m_ovf;
  logic [P-1:0] s_rpc [D];
  logic [P-1:0] s_epc [D];
  logic [L-1:0] s_em  [D];
  logic [L-1:0] s_nm  [D];
  logic         s_ph  [D];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic be, input logic [L-1:0] c, input logic [P-1:0] tp,
                      input logic [P-1:0] ep, input logic [P-1:0] rp,
                      input logic pe, input logic [P-1:0] pc, input string req);
    logic [L-1:0] mid, tk, el, e_mask;
    int   e_path;
    logic e_rv;
    logic [P-1:0] e_rpc;
    logic hit, flp, pp, live;
    br_en = be; br_cond = c; br_taken_pc = tp; br_else_pc = ep; br_reconv_pc = rp;
    pc_en = pe; pc_now = pc;
    hit = pe && m_depth > 0 && pc == s_rpc[m_depth > 0 ? m_depth-1 : 0];
    flp = hit && !s_ph[m_depth-1];
    pp  = hit && s_ph[m_depth-1];
    if (pe && m_depth > 0) m_cnt++;
    mid = pp ? s_nm[m_depth-1] : m_mask;
    live = be && !flp;
    tk = mid & c; el = mid & ~c;
    e_mask = mid; e_path = 0; e_rv = 0; e_rpc = '0;
    if (pp) begin m_depth--; e_path = 3; end
    if (flp) begin
      s_ph[m_depth-1] = 1'b1; e_mask = s_em[m_depth-1];
      e_path = 2; e_rv = 1; e_rpc = s_epc[m_depth-1];
    end
    if (live) begin
      if (tk != '0 && el != '0) begin
        if (m_depth == D) begin m_ovf = 1'b1; e_path = pp ? 3 : 0; end
        else begin
          s_rpc[m_depth] = rp; s_epc[m_depth] = ep; s_em[m_depth] = el;
          s_nm[m_depth] = mid; s_ph[m_depth] = 1'b0; m_depth++;
          e_mask = tk; e_path = 1; e_rv = 1; e_rpc = tp;
        end
      end else if (el != '0) begin e_path = 2; e_rv = 1; e_rpc = ep; end
      else begin e_path = 1; e_rv = 1; e_rpc = tp; end
    end
    m_mask = e_mask;
    @(posedge clk); #2;
    chk(req, "mask", active_mask, e_mask);
    chk(req, "path", path_sel, e_path);
    chk(req, "redirect", redirect_valid, e_rv);
    if (e_rv) chk(req, "redirect_pc", redirect_pc, e_rpc);
    chk(req, "depth", stack_depth, m_depth);
    chk("R8", "overflow", overflow, m_ovf);
    chk("R9", "serial", serial_cycles, m_cnt);
    br_en = 1'b0; pc_en = 1'b0;
  endtask

  task automatic issue(input logic [P-1:0] pc, input string req);
    step(1'b0, '0, '0, '0, '0, 1'b1, pc, req);
  endtask

  task automatic branch(input logic [L-1:0] c, input logic [P-1:0] rp, input string req);
    step(1'b1, c, rp - 32'h100, rp - 32'h80, rp, 1'b0, '0, req);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_mask = '1; m_depth = 0; m_cnt = 0; m_ovf = 1'b0;
    for (int i = 0; i < D; i++) begin
      s_rpc[i] = '0; s_epc[i] = '0; s_em[i] = '0; s_nm[i] = '0; s_ph[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1", "mask", active_mask, {L{1'b1}});
    chk("R1", "depth", stack_depth, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "serial", serial_cycles, 0);
    chk("R1", "path", path_sel, 0);
    chk("R1", "redirect", redirect_valid, 0);

    // R11 idle and plain issue
    issue(32'h5000, "R11");
    step(1'b0, '0, '0, '0, '0, 1'b0, '0, "R11");

    // R2 uniform branches on the full mask
    branch('1, 32'h2000, "R2");
    branch('0, 32'h2000, "R2");

    // R3 R5 R6 R9: split sweep, single-lane and hashed patterns
    for (int k = 0; k < 64; k++) begin
      logic [L-1:0] c;
      logic [P-1:0] rp;
      c  = (k < 32) ? (32'h1 << k) : (32'(k) * 32'h9E37_79B9);
      if (c == '0 || c == '1) c = 32'h0000_F0F0;
      rp = 32'h3000 + 32'(k) * 32'h400;
      branch(c, rp, "R3");
      issue(rp - 32'h100, "R9");
      issue(rp - 32'hFC, "R9");
      issue(rp, "R5");
      for (int j = 0; j < (k % 4) + 1; j++) issue(rp - 32'h80 + 32'(j) * 4, "R9");
      issue(rp, "R6");
    end

    // R4 R7 R8: nest eight levels, each dropping one lane; ninth refused
    for (int l = 0; l < D; l++) branch(~(32'h1 << l), 32'h8_0000 + 32'(l) * 32'h1000, "R7");
    branch('1, 32'h9_0000, "R4");               // inactive lanes 0..7 remain off
    branch(32'h0000_00FF, 32'h9_0000, "R4");    // only dead lanes true: uniform false
    branch(~(32'h1 << 8), 32'h9_8000, "R8");    // split on full stack
    branch(32'h0000_FF00, 32'h9_8000, "R8");    // still refused, flag holds
    for (int l = D - 1; l >= 0; l--) begin
      issue(32'h8_0000 + 32'(l) * 32'h1000, "R7");
      issue(32'h8_0000 + 32'(l) * 32'h1000, "R7");
    end

    // R10: branch on a switch arrival is dropped; on a pop arrival it sees the restored mask
    branch(32'hFFFF_0000, 32'hA_0000, "R10");
    step(1'b1, 32'h0000_00FF, 32'hB_0000, 32'hB_0100, 32'hB_0200, 1'b1, 32'hA_0000, "R10");
    step(1'b1, 32'h0000_FFFF, 32'hC_0000, 32'hC_0100, 32'hC_0200, 1'b1, 32'hA_0000, "R10");
    issue(32'hC_0200, "R5");
    issue(32'hC_0200, "R6");
    step(1'b1, '1, 32'hD_0000, 32'hD_0100, 32'hD_0200, 1'b1, 32'h5555, "R2");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule